// File: doc/BRIEF.md
# DAC Sample Conditioning Pipeline

This block sits between a signal-processing datapath and one converter lane. Every DAC clock cycle it takes one signed 16-bit sample and passes it through four stages in a fixed order. The first stage is a digital gain, built from a fine linear trim followed by a coarse power-of-two attenuation. The second cuts the sample to the converter's resolution and can add half an output LSB. The third can negate the sample. The last stage is a delay line that can add a programmable number of cycles. The result leaves as a left-justified 16-bit word.

All settings are static configuration inputs, meant to be changed while the stream is idle. The one exception is the delay offset. A new offset takes effect on the very next output, and nothing suppresses the glitch this causes. With every setting at zero, the block gives unity gain, no inversion and no extra delay. Samples then arrive at the output five clock cycles after they enter.

Top module: `dac_cond_pipe`

## Requirements
- R1: While reset is high, and on the first cycle after it, the output word is 0.
- R2: With every setting at zero, the output equals the truncated input five clock cycles later.
- R3: Fine gain with the 4-bit value v gives y = x - floor(x*v/32) in two's complement. The magnitude never exceeds that of x, and the sign is kept.
- R4: Coarse gain with the 3-bit value c is an arithmetic right shift of the fine-stage result by c bits (gain 2^-c). It rounds toward minus infinity.
- R5: With OUT_BITS below 16, the low 16-OUT_BITS bits of the gained sample are cleared (truncation toward minus infinity). The kept bits stay at positions 15 down to 16-OUT_BITS.
- R6: With half-LSB compensation on and OUT_BITS below 16, bit 15-OUT_BITS of the truncated word is set. With OUT_BITS equal to 16, this setting has no effect.
- R7: With inversion on, the truncated word is negated. The value -32768 (0x8000) becomes +32767 (0x7FFF).
- R8: With the delay enabled and a 5-bit offset d, the output is delayed by 64+d extra cycles. With the delay disabled, no cycles are added.
- R9: A change of the delay offset while enabled applies from the next output onward. That output comes from the sample written 64+d_new cycles earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DAC sample clock |
| rst | input | 1 | Synchronous active-high reset |
| in_sample | input | 16 | Signed input sample, one per cycle |
| cfg_coarse | input | 3 | Coarse attenuation, shift right by this amount |
| cfg_fine | input | 4 | Fine trim numerator, gain 1 - v/32 |
| cfg_half_lsb | input | 1 | Add half an output LSB after truncation |
| cfg_invert | input | 1 | Negate the output sample |
| cfg_dly_en | input | 1 | Enable the programmable delay |
| cfg_dly_val | input | 5 | Delay offset added to the base of 64 cycles |
| out_sample | output | 16 | Conditioned, left-justified output sample |

## Verification
The bench builds the pipeline with OUT_BITS = 12, so four low bits are dropped. This makes the truncation floor and the half-LSB bit (bit 3) visible, and lets inversion act on words that carry that bit. The delay line keeps its default depth of 128 and base of 64. Both the shortest (64) and longest (95) delays therefore run against a buffer that wraps. The test also switches the offset mid-stream from 95 down to 66 cycles. The stimulus forces -32768, +32767 and -1 into the stream at intervals, so sign handling, rounding toward minus infinity and negation saturation are all exercised.

// File: rtl/dac_cond_pkg.sv
package dac_cond_pkg;
  localparam int SAMPLE_W = 16;
  typedef logic signed [SAMPLE_W-1:0] sample_t;
  localparam sample_t SAMPLE_MIN = sample_t'(16'sh8000);
  localparam sample_t SAMPLE_MAX = sample_t'(16'sh7FFF);
endpackage

// File: rtl/dac_gain_stage.sv
module dac_gain_stage
  import dac_cond_pkg::*;
#(
  parameter int COARSE_W   = 3,
  parameter int FINE_W     = 4,
  parameter int FINE_SHIFT = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  sample_t             din,
  input  logic [COARSE_W-1:0] coarse,
  input  logic [FINE_W-1:0]   fine,
  output sample_t             dout
);
  localparam int PROD_W = SAMPLE_W + FINE_W + 1;

  logic signed [PROD_W-1:0] x_ext;
  logic signed [PROD_W-1:0] v_ext;
  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] trimmed;
  sample_t fine_q;
  sample_t coarse_q;

  always_comb begin
    x_ext   = PROD_W'(din);
    v_ext   = $signed({{(PROD_W-FINE_W){1'b0}}, fine});
    prod    = x_ext * v_ext;
    trimmed = x_ext - (prod >>> FINE_SHIFT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fine_q   <= '0;
      coarse_q <= '0;
    end else begin
      fine_q   <= sample_t'(trimmed);
      coarse_q <= fine_q >>> coarse;
    end
  end

  assign dout = coarse_q;

  // R3: the fine trim never grows the magnitude and keeps the sign
  assert_fine_pos_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(din) >= 0) |-> (fine_q >= 0 && fine_q <= $past(din)));
  assert_fine_neg_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(din) < 0) |-> (fine_q <= 0 && fine_q >= $past(din)));
  // R4: the coarse shift attenuates and keeps the sign
  assert_coarse_shrink_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(fine_q) >= 0) |-> (coarse_q >= 0 && coarse_q <= $past(fine_q)));
  assert_coarse_neg_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(fine_q) < 0) |-> (coarse_q < 0 && coarse_q >= $past(fine_q)));
endmodule

// File: rtl/dac_trunc_stage.sv
module dac_trunc_stage
  import dac_cond_pkg::*;
#(
  parameter int OUT_BITS = 16
) (
  input  logic    clk,
  input  logic    rst,
  input  sample_t din,
  input  logic    half_lsb,
  output sample_t dout
);
  localparam int DROP = SAMPLE_W - OUT_BITS;

  sample_t trunc_next;
  sample_t trunc_q;

  generate
    if (OUT_BITS < 8 || OUT_BITS > SAMPLE_W) begin : g_bad_bits
      $error("OUT_BITS must lie between 8 and 16");
    end
    if (DROP > 0) begin : g_cut
      localparam logic [SAMPLE_W-1:0] KEEP_MASK = {SAMPLE_W{1'b1}} << DROP;
      localparam logic [SAMPLE_W-1:0] HALF_BIT  = SAMPLE_W'(1) << (DROP - 1);
      always_comb begin
        trunc_next = din & KEEP_MASK;
        if (half_lsb) trunc_next = trunc_next | HALF_BIT;
      end
      // R5: truncation floors the sample by less than one output LSB
      assert_trunc_floor_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(half_lsb)) |->
        (trunc_q <= $past(din) &&
         (32'($past(din)) - 32'(trunc_q)) < (32'sd1 <<< DROP)));
      // R6: the compensation lands strictly above the floored value
      assert_half_lsb_R6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(half_lsb)) |->
        (trunc_q[DROP-1] && (32'($past(din)) - 32'(trunc_q)) < (32'sd1 <<< (DROP - 1))));
    end else begin : g_full
      always_comb trunc_next = din;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) trunc_q <= '0;
    else     trunc_q <= trunc_next;
  end

  assign dout = trunc_q;
endmodule

// File: rtl/dac_invert_stage.sv
module dac_invert_stage
  import dac_cond_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  sample_t din,
  input  logic    invert,
  output sample_t dout
);
  sample_t inv_q;

  always_ff @(posedge clk) begin
    if (rst)                        inv_q <= '0;
    else if (!invert)               inv_q <= din;
    else if (din == SAMPLE_MIN)     inv_q <= SAMPLE_MAX;
    else                            inv_q <= -din;
  end

  assign dout = inv_q;

  // R7: negating the most negative code saturates
  assert_inv_sat_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(invert) && $past(din) == SAMPLE_MIN) |-> (inv_q == SAMPLE_MAX));
  // R7: inversion off passes the sample untouched
  assert_inv_pass_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(invert)) |-> (inv_q == $past(din)));
endmodule

// File: rtl/dac_delay_line.sv
module dac_delay_line
  import dac_cond_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int BASE  = 64,
  parameter int VAL_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  sample_t          din,
  input  logic             en,
  input  logic [VAL_W-1:0] val,
  output sample_t          dout
);
  localparam int AW = $clog2(DEPTH);

  generate
    if (DEPTH < BASE + (1 << VAL_W) || DEPTH != (1 << AW)) begin : g_bad_depth
      $error("DEPTH must be a power of two covering BASE plus the largest offset");
    end
  endgenerate

  logic [SAMPLE_W-1:0] mem [DEPTH];
  logic [AW-1:0]       wr_ptr;
  logic [AW-1:0]       rd_ptr;
  sample_t             out_q;

  assign rd_ptr = wr_ptr - (AW'(BASE) + AW'(val));

  always_ff @(posedge clk) begin
    mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      out_q  <= '0;
    end else begin
      wr_ptr <= wr_ptr + AW'(1);
      out_q  <= en ? sample_t'(mem[rd_ptr]) : din;
    end
  end

  assign dout = out_q;

  // R8: with the delay off the stage adds exactly its one register
  assert_bypass_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(en)) |-> (out_q == $past(din)));
  // R8: the write pointer advances once per cycle
  assert_wptr_step_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (wr_ptr == $past(wr_ptr) + AW'(1)));
endmodule

// File: rtl/dac_cond_pipe.sv
module dac_cond_pipe
  import dac_cond_pkg::*;
#(
  parameter int OUT_BITS   = 16,
  parameter int COARSE_W   = 3,
  parameter int FINE_W     = 4,
  parameter int FINE_SHIFT = 5,
  parameter int DLY_DEPTH  = 128,
  parameter int DLY_BASE   = 64,
  parameter int DLY_VAL_W  = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [15:0]          in_sample,
  input  logic [COARSE_W-1:0]  cfg_coarse,
  input  logic [FINE_W-1:0]    cfg_fine,
  input  logic                 cfg_half_lsb,
  input  logic                 cfg_invert,
  input  logic                 cfg_dly_en,
  input  logic [DLY_VAL_W-1:0] cfg_dly_val,
  output logic [15:0]          out_sample
);
  sample_t gained;
  sample_t truncated;
  sample_t inverted;
  sample_t delayed;

  dac_gain_stage #(
    .COARSE_W  (COARSE_W),
    .FINE_W    (FINE_W),
    .FINE_SHIFT(FINE_SHIFT)
  ) u_gain (
    .clk   (clk),
    .rst   (rst),
    .din   (sample_t'(in_sample)),
    .coarse(cfg_coarse),
    .fine  (cfg_fine),
    .dout  (gained)
  );

  dac_trunc_stage #(
    .OUT_BITS(OUT_BITS)
  ) u_trunc (
    .clk     (clk),
    .rst     (rst),
    .din     (gained),
    .half_lsb(cfg_half_lsb),
    .dout    (truncated)
  );

  dac_invert_stage u_inv (
    .clk   (clk),
    .rst   (rst),
    .din   (truncated),
    .invert(cfg_invert),
    .dout  (inverted)
  );

  dac_delay_line #(
    .DEPTH(DLY_DEPTH),
    .BASE (DLY_BASE),
    .VAL_W(DLY_VAL_W)
  ) u_dly (
    .clk (clk),
    .rst (rst),
    .din (inverted),
    .en  (cfg_dly_en),
    .val (cfg_dly_val),
    .dout(delayed)
  );

  assign out_sample = delayed;

  // R1: the output is cleared on the cycle after reset
  assert_reset_zero_R1: assert property (@(posedge clk)
    $past(rst) |-> (out_sample == 16'h0000));
endmodule

// File: tb/tb_dac_cond_pipe.sv
module tb_dac_cond_pipe;
  localparam int OB  = 12;
  localparam int LAT = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] din = '0;
  logic [2:0]  coarse = '0;
  logic [3:0]  fine = '0;
  logic        half = 1'b0;
  logic        inv = 1'b0;
  logic        den = 1'b0;
  logic [4:0]  dval = '0;
  logic [15:0] dout;

  int checks = 0;
  int fails  = 0;
  logic [31:0] rng = 32'h1357_9BDF;
  logic signed [15:0] hist [0:1023];

  always #5 clk = ~clk;

  dac_cond_pipe #(.OUT_BITS(OB)) dut (
    .clk(clk), .rst(rst), .in_sample(din),
    .cfg_coarse(coarse), .cfg_fine(fine), .cfg_half_lsb(half),
    .cfg_invert(inv), .cfg_dly_en(den), .cfg_dly_val(dval),
    .out_sample(dout)
  );

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog expired got=hang exp=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  function automatic logic signed [15:0] model(input logic signed [15:0] x);
    int t;
    t = int'(x);
    t = t - ((t * int'(fine)) >>> 5);
    t = t >>> int'(coarse);
    t = (t >>> (16 - OB)) <<< (16 - OB);
    if (half) t = t + (1 << (15 - OB));
    if (inv) t = (t == -32768) ? 32767 : -t;
    return 16'(t);
  endfunction

  function automatic logic signed [15:0] next_sample(input int k);
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
    case (k % 29)
      0:       return 16'sh8000;
      1:       return 16'sh7FFF;
      2:       return -16'sd1;
      3:       return 16'sd0;
      default: return 16'(rng);
    endcase
  endfunction

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic stream(input string tag, input int n, input int swap_at, input int d1);
    int dcur;
    int lat;
    dcur = int'(dval);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      lat = LAT + (den ? 64 + dcur : 0);
      if (k >= lat) check(tag, dout, model(hist[k - lat]));
      if (k == swap_at) begin
        dcur = d1;
        dval = 5'(d1);
      end
      hist[k] = next_sample(k);
      din = hist[k];
    end
  endtask

  task automatic t_reset();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      din = 16'h7FFF;
      check("R1 during reset", dout, 16'h0000);
    end
    rst = 1'b0;
    @(negedge clk);
    check("R1 first cycle after reset", dout, 16'h0000);
  endtask

  task automatic t_unity();
    coarse = '0; fine = '0; half = 1'b0; inv = 1'b0; den = 1'b0;
    stream("R2 R5 unity and truncation", 150, -1, 0);
  endtask

  task automatic t_fine();
    fine = 4'd15;
    stream("R3 fine trim 15", 120, -1, 0);
    fine = 4'd8;
    stream("R3 fine trim 8", 120, -1, 0);
    fine = 4'd1;
    stream("R3 fine trim 1", 120, -1, 0);
    fine = '0;
  endtask

  task automatic t_coarse();
    coarse = 3'd3;
    stream("R4 coarse shift 3", 120, -1, 0);
    coarse = 3'd7; fine = 4'd5;
    stream("R4 coarse shift 7 with fine 5", 120, -1, 0);
    coarse = '0; fine = '0;
  endtask

  task automatic t_half();
    half = 1'b1;
    stream("R6 half lsb", 120, -1, 0);
    coarse = 3'd2;
    stream("R6 half lsb with coarse 2", 120, -1, 0);
    coarse = '0; half = 1'b0;
  endtask

  task automatic t_invert();
    inv = 1'b1;
    stream("R7 invert", 150, -1, 0);
    half = 1'b1; fine = 4'd3;
    stream("R7 invert with half lsb and fine 3", 150, -1, 0);
    inv = 1'b0; half = 1'b0; fine = '0;
  endtask

  task automatic t_delay();
    den = 1'b1; dval = 5'd0;
    stream("R8 delay 64", 300, -1, 0);
    dval = 5'd31;
    stream("R8 delay 95", 300, -1, 0);
    den = 1'b0;
    stream("R8 delay disabled", 60, -1, 0);
  endtask

  task automatic t_delay_swap();
    den = 1'b1; dval = 5'd31;
    stream("R9 delay change 95 to 66", 400, 250, 2);
    den = 1'b0; dval = '0;
  endtask

  initial begin
    t_reset();
    t_unity();
    t_fine();
    t_coarse();
    t_half();
    t_invert();
    t_delay();
    t_delay_swap();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule